// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the programming state of one DMA channel and exposes it on a small memory-mapped bus. Software sets up the descriptor pointer, start address, counts, strides and peripheral selection, then writes the configuration word. A configuration write with the enable bit set arms the channel: the run flag rises, a one-cycle start strobe goes to the transfer engine, and the current-value registers are loaded from the programmed ones. A configuration write with the enable bit clear drops the run flag and sends a one-cycle stop strobe.

The transfer engine is outside this block. It reads the programmed values from dedicated output pins and reports back with a done pulse, an error pulse and an update strobe that carries the current address and remaining counts. While the channel runs, the block protects the programmed set: bus writes to pointers, addresses, counts, strides, the peripheral map and the current counts are dropped without an error. The status word mixes two write-1-to-clear flags with a run bit that only hardware controls.

The request side is a valid/ready stream. `req_ready` is held high, so the block accepts one request on every cycle that `req_valid` is high, and there is no back-pressure. Each accepted request gets exactly one response pulse on the next cycle, and the response side cannot stall.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register reads zero, the run flag is low and the peripheral map equals the `PMAP_RST` parameter.
- R2: Each accepted request gets `rsp_valid` high in the next cycle. A read returns the register value from before that cycle's update. A 16-bit read (`req_wide`=0) returns the low half with the upper half zero. Slots are 4 bytes apart: next descriptor 0x00, start address 0x04, configuration 0x08, X count 0x10, X stride 0x14, Y count 0x18, Y stride 0x1C, current descriptor 0x20, current address 0x24, status 0x28, peripheral map 0x2C, current X count 0x30, current Y count 0x38.
- R3: A 16-bit write to a 32-bit register replaces only bits 15:0. A 32-bit write to a 16-bit register keeps only bits 15:0.
- R4: While the run flag is high, writes to every register except configuration and status are dropped, with no error response.
- R5: A configuration write with bit 0 set raises the run flag in the next cycle together with a one-cycle `eng_start`. In the same cycle it loads the current descriptor pointer from the next descriptor, the current address from the start address, and each current count from its count, with a count of 0 loaded as 0xFFFF.
- R6: A configuration write with bit 0 clear lowers the run flag in the next cycle and pulses `eng_stop` for one cycle.
- R7: Status bit 0 (done) and bit 1 (error) are cleared by writing 1 to them. Bit 3 (run) is unaffected by status writes. A hardware set in the same cycle as a clear wins.
- R8: An `eng_done` pulse sets the done bit and clears the run flag, unless a starting configuration write lands in the same cycle. An `eng_err` pulse sets the error bit.
- R9: A peripheral map write keeps bit 6 (channel type) and replaces all other bits.
- R10: A misaligned access (address bits 1:0 not zero) or a write to a reserved slot (0x0C, 0x34, 0x3C) returns `rsp_err` with zero data and changes no state. Reads of reserved slots return zero without error.
- R11: `eng_upd` loads the current address and the current X and Y counts only while the run flag is high. A start in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| req_addr | input | 6 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Error response |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_stop | output | 1 | One-cycle stop strobe to the engine |
| chan_run | output | 1 | Channel running flag |
| cfg_word | output | 16 | Configuration word |
| next_desc | output | 32 | Next descriptor pointer |
| start_addr | output | 32 | Start address |
| x_count | output | 16 | Programmed X count |
| x_step | output | 16 | Programmed X stride |
| y_count | output | 16 | Programmed Y count |
| y_step | output | 16 | Programmed Y stride |
| periph_map | output | 16 | Peripheral map |
| eng_done | input | 1 | Engine work unit finished |
| eng_err | input | 1 | Engine error |
| eng_upd | input | 1 | Engine current-value update strobe |
| upd_addr | input | 32 | Updated current address |
| upd_x | input | 16 | Updated current X count |
| upd_y | input | 16 | Updated current Y count |

## Verification
All results are due exactly one clock edge after their cause. The response to a request, the run flag, the start and stop strobes after a configuration write, the status bits after an engine pulse, and the register contents after a write or update all appear at that edge. The bench drives inputs just after a rising edge and compares every output against its behavioural model at the following falling edge, so each comparison sees the cycle in which the result has just become due. Directed reads then observe the protected, reserved and current-value registers through the bus one cycle after each stimulus, with the expected constants worked out from the requirements.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DW     = 32;
  localparam int HW     = 16;
  localparam int CFG_EN = 0;
  localparam int ST_DONE = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RUN  = 3;
  localparam int PMAP_TYPE = 6;

  typedef enum logic [3:0] {
    SL_NDP   = 4'd0,  SL_SADDR = 4'd1,  SL_CFG   = 4'd2,  SL_PAD0  = 4'd3,
    SL_XCNT  = 4'd4,  SL_XMOD  = 4'd5,  SL_YCNT  = 4'd6,  SL_YMOD  = 4'd7,
    SL_CDP   = 4'd8,  SL_CADDR = 4'd9,  SL_STAT  = 4'd10, SL_PMAP  = 4'd11,
    SL_CXCNT = 4'd12, SL_PAD1  = 4'd13, SL_CYCNT = 4'd14, SL_PAD2  = 4'd15
  } slot_e;

  typedef struct packed {
    logic    ok;
    logic    bad;
    logic    wr;
    logic    wide;
    slot_e   slot;
  } acc_t;
endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec
  import dmac_pkg::*;
#(
  parameter int SLOT_W = 4,
  localparam int ADDR_W = SLOT_W + 2
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  output acc_t              acc
);
  logic misal;
  logic pad;
  slot_e slot;

  always_comb begin
    slot  = slot_e'(req_addr[ADDR_W-1:2]);
    misal = |req_addr[1:0];
    pad   = (slot == SL_PAD0) || (slot == SL_PAD1) || (slot == SL_PAD2);
    acc.slot = slot;
    acc.wr   = req_write;
    acc.wide = req_wide;
    acc.bad  = req_valid && (misal || (req_write && pad));
    acc.ok   = req_valid && !acc.bad;
  end
endmodule

// File: rtl/dmac_lockreg.sv
module dmac_lockreg
  import dmac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wide,
  input  logic          lock,
  input  logic [DW-1:0] wdata,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  output logic [W-1:0]  q
);
  logic [W-1:0] wval;

  generate
    if (W > HW) begin : g_wide
      assign wval = wide ? wdata[W-1:0] : {q[W-1:HW], wdata[HW-1:0]};
    end else begin : g_narrow
      assign wval = wdata[W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              q <= '0;
    else if (load)           q <= load_val;
    else if (we && !lock)    q <= wval;
  end

  // R4: a locked cell only moves through the hardware load path
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !load) |=> $stable(q));
endmodule

// File: rtl/dmac_status_ctl.sv
module dmac_status_ctl
  import dmac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic       cfg_en,
  input  logic       stat_wr,
  input  logic [1:0] stat_clr,
  input  logic       eng_done,
  input  logic       eng_err,
  output logic       run,
  output logic       done,
  output logic       err,
  output logic       start_p,
  output logic       stop_p
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; done <= 1'b0; err <= 1'b0;
      start_p <= 1'b0; stop_p <= 1'b0;
    end else begin
      start_p <= cfg_wr && cfg_en;
      stop_p  <= cfg_wr && !cfg_en;
      if (cfg_wr)        run <= cfg_en;
      else if (eng_done) run <= 1'b0;
      done <= (done && !(stat_wr && stat_clr[ST_DONE])) || eng_done;
      err  <= (err  && !(stat_wr && stat_clr[ST_ERR]))  || eng_err;
    end
  end

  a_r5_rise_has_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> start_p);
  a_r6_stop_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |-> !run);
  a_r8_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !cfg_wr) |=> (!run && done));
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> err);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmac_pkg::*;
#(
  parameter int          SLOT_W   = 4,
  parameter logic [15:0] PMAP_RST = 16'h0045,
  localparam int ADDR_W = SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_err,
  output logic              eng_start,
  output logic              eng_stop,
  output logic              chan_run,
  output logic [HW-1:0]     cfg_word,
  output logic [DW-1:0]     next_desc,
  output logic [DW-1:0]     start_addr,
  output logic [HW-1:0]     x_count,
  output logic [HW-1:0]     x_step,
  output logic [HW-1:0]     y_count,
  output logic [HW-1:0]     y_step,
  output logic [HW-1:0]     periph_map,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_upd,
  input  logic [DW-1:0]     upd_addr,
  input  logic [HW-1:0]     upd_x,
  input  logic [HW-1:0]     upd_y
);
  localparam int NPARM = 4;

  acc_t acc;
  logic wr_ok, rd_ok, cfg_wr, start_now, upd_now, st_done, st_err;
  logic [HW-1:0] parm_q [NPARM];
  logic [DW-1:0] cdp_q, caddr_q, rmux;
  logic [HW-1:0] cx_q, cy_q, cfg_q, pmap_q;

  assign req_ready = 1'b1;

  dmac_addr_dec #(.SLOT_W(SLOT_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_addr(req_addr), .acc(acc));

  assign wr_ok     = acc.ok && acc.wr;
  assign rd_ok     = acc.ok && !acc.wr;
  assign cfg_wr    = wr_ok && (acc.slot == SL_CFG);
  assign start_now = cfg_wr && req_wdata[CFG_EN];
  assign upd_now   = eng_upd && chan_run && !start_now;

  dmac_status_ctl u_stat (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(req_wdata[CFG_EN]),
    .stat_wr(wr_ok && (acc.slot == SL_STAT)), .stat_clr(req_wdata[1:0]),
    .eng_done(eng_done), .eng_err(eng_err), .run(chan_run), .done(st_done),
    .err(st_err), .start_p(eng_start), .stop_p(eng_stop));

  // programmed 32-bit pointers
  dmac_lockreg #(.W(DW)) u_ndp (
    .clk(clk), .rst_n(rst_n), .we(wr_ok && acc.slot == SL_NDP), .wide(acc.wide),
    .lock(chan_run), .wdata(req_wdata), .load(1'b0), .load_val('0), .q(next_desc));
  dmac_lockreg #(.W(DW)) u_sa (
    .clk(clk), .rst_n(rst_n), .we(wr_ok && acc.slot == SL_SADDR), .wide(acc.wide),
    .lock(chan_run), .wdata(req_wdata), .load(1'b0), .load_val('0), .q(start_addr));

  // counts and strides, consecutive slots
  for (genvar g = 0; g < NPARM; g++) begin : g_parm
    dmac_lockreg #(.W(HW)) u_p (
      .clk(clk), .rst_n(rst_n),
      .we(wr_ok && (acc.slot == slot_e'(int'(SL_XCNT) + g))), .wide(acc.wide),
      .lock(chan_run), .wdata(req_wdata), .load(1'b0), .load_val('0), .q(parm_q[g]));
  end
  assign x_count = parm_q[0];
  assign x_step  = parm_q[1];
  assign y_count = parm_q[2];
  assign y_step  = parm_q[3];

  // current values: loaded at start or by engine update
  dmac_lockreg #(.W(DW)) u_cdp (
    .clk(clk), .rst_n(rst_n), .we(wr_ok && acc.slot == SL_CDP), .wide(acc.wide),
    .lock(chan_run), .wdata(req_wdata), .load(start_now), .load_val(next_desc),
    .q(cdp_q));
  dmac_lockreg #(.W(DW)) u_ca (
    .clk(clk), .rst_n(rst_n), .we(wr_ok && acc.slot == SL_CADDR), .wide(acc.wide),
    .lock(chan_run), .wdata(req_wdata), .load(start_now || upd_now),
    .load_val(start_now ? start_addr : upd_addr), .q(caddr_q));
  dmac_lockreg #(.W(HW)) u_cx (
    .clk(clk), .rst_n(rst_n), .we(wr_ok && acc.slot == SL_CXCNT), .wide(acc.wide),
    .lock(chan_run), .wdata(req_wdata), .load(start_now || upd_now),
    .load_val(start_now ? ((x_count == '0) ? '1 : x_count) : upd_x), .q(cx_q));
  dmac_lockreg #(.W(HW)) u_cy (
    .clk(clk), .rst_n(rst_n), .we(wr_ok && acc.slot == SL_CYCNT), .wide(acc.wide),
    .lock(chan_run), .wdata(req_wdata), .load(start_now || upd_now),
    .load_val(start_now ? ((y_count == '0) ? '1 : y_count) : upd_y), .q(cy_q));

  // configuration and peripheral map
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pmap_q <= PMAP_RST;
    end else begin
      if (cfg_wr) cfg_q <= req_wdata[HW-1:0];
      if (wr_ok && acc.slot == SL_PMAP && !chan_run) begin
        pmap_q <= req_wdata[HW-1:0];
        pmap_q[PMAP_TYPE] <= pmap_q[PMAP_TYPE];
      end
    end
  end
  assign cfg_word   = cfg_q;
  assign periph_map = pmap_q;

  always_comb begin
    rmux = '0;
    unique case (acc.slot)
      SL_NDP:   rmux = next_desc;
      SL_SADDR: rmux = start_addr;
      SL_CFG:   rmux[HW-1:0] = cfg_q;
      SL_XCNT:  rmux[HW-1:0] = x_count;
      SL_XMOD:  rmux[HW-1:0] = x_step;
      SL_YCNT:  rmux[HW-1:0] = y_count;
      SL_YMOD:  rmux[HW-1:0] = y_step;
      SL_CDP:   rmux = cdp_q;
      SL_CADDR: rmux = caddr_q;
      SL_STAT: begin
        rmux[ST_DONE] = st_done;
        rmux[ST_ERR]  = st_err;
        rmux[ST_RUN]  = chan_run;
      end
      SL_PMAP:  rmux[HW-1:0] = pmap_q;
      SL_CXCNT: rmux[HW-1:0] = cx_q;
      SL_CYCNT: rmux[HW-1:0] = cy_q;
      default:  rmux = '0;
    endcase
    if (!acc.wide) rmux[DW-1:HW] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= acc.bad;
      rsp_rdata <= rd_ok ? rmux : '0;
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r10_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == '0));
  a_r9_type_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(pmap_q[PMAP_TYPE]));
  a_r4_cfg_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q));
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  localparam logic [15:0] PMAP_RST = 16'h0045;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_wide = 0;
  logic [5:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic eng_done = 0, eng_err = 0, eng_upd = 0;
  logic [31:0] upd_addr = 0;
  logic [15:0] upd_x = 0, upd_y = 0;
  logic req_ready, rsp_valid, rsp_err, eng_start, eng_stop, chan_run;
  logic [31:0] rsp_rdata, next_desc, start_addr;
  logic [15:0] cfg_word, x_count, x_step, y_count, y_step, periph_map;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs #(.PMAP_RST(PMAP_RST)) u_dma_chan_regs (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mr [16];
  logic [31:0] mo [16];
  logic m_run, m_done, m_err, e_valid, e_errr, e_start, e_stop;
  logic [31:0] e_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mr[i] = 0;
      mr[11] = {16'h0, PMAP_RST};
      m_run = 0; m_done = 0; m_err = 0;
      e_valid = 0; e_errr = 0; e_start = 0; e_stop = 0; e_rdata = 0;
    end else begin
      int s;
      logic [31:0] w;
      logic was_run;
      for (int i = 0; i < 16; i++) mo[i] = mr[i];
      mo[10] = {28'h0, m_run, 1'b0, m_err, m_done};
      was_run = m_run;
      e_valid = req_valid; e_errr = 0; e_rdata = 0; e_start = 0; e_stop = 0;
      s = int'(req_addr[5:2]);
      if (req_valid) begin
        if (req_addr[1:0] != 0 || (req_write && (s == 3 || s == 13 || s == 15))) e_errr = 1;
        else if (!req_write) e_rdata = req_wide ? mo[s] : (mo[s] & 32'hFFFF);
        else begin
          w = req_wide ? req_wdata : {mo[s][31:16], req_wdata[15:0]};
          if (s == 0 || s == 1 || s == 8 || s == 9) begin
            if (!was_run) mr[s] = w;
          end else if (s == 4 || s == 5 || s == 6 || s == 7 || s == 12 || s == 14) begin
            if (!was_run) mr[s] = w & 32'hFFFF;
          end else if (s == 11) begin
            if (!was_run) mr[11] = (mo[11] & 32'h40) | (w & 32'hFFBF);
          end else if (s == 2) begin
            mr[2] = w & 32'hFFFF;
            if (w[0]) begin
              e_start = 1; m_run = 1;
              mr[8] = mo[0]; mr[9] = mo[1];
              mr[12] = (mo[4] == 0) ? 32'hFFFF : mo[4];
              mr[14] = (mo[6] == 0) ? 32'hFFFF : mo[6];
            end else begin
              e_stop = 1; m_run = 0;
            end
          end else if (s == 10) begin
            if (w[0]) m_done = 0;
            if (w[1]) m_err = 0;
          end
        end
      end
      if (eng_upd && was_run && !e_start) begin
        mr[9] = upd_addr; mr[12] = {16'h0, upd_x}; mr[14] = {16'h0, upd_y};
      end
      if (eng_done) begin m_done = 1; if (!e_start && !e_stop) m_run = 0; end
      if (eng_err) m_err = 1;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 rsp_valid", {31'h0, rsp_valid}, {31'h0, e_valid});
    chk("R2 rsp_rdata", rsp_rdata, e_rdata);
    chk("R10 rsp_err", {31'h0, rsp_err}, {31'h0, e_errr});
    chk("R5 chan_run", {31'h0, chan_run}, {31'h0, m_run});
    chk("R5 eng_start", {31'h0, eng_start}, {31'h0, e_start});
    chk("R6 eng_stop", {31'h0, eng_stop}, {31'h0, e_stop});
    chk("R9 periph_map", {16'h0, periph_map}, mr[11]);
    chk("R3 start_addr", start_addr, mr[1]);
    chk("R4 x_count", {16'h0, x_count}, mr[4]);
    chk("R4 cfg_word", {16'h0, cfg_word}, mr[2]);
  end

  task automatic bus(input logic wr, input logic wide, input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic wide, input logic [5:0] a, input logic [31:0] exp, input string req);
    bus(0, wide, a, 0);
    chk(req, rsp_rdata, exp);
    chk(req, {31'h0, rsp_err}, 32'h0);
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    if (which == 0) eng_done = 1; else if (which == 1) eng_err = 1; else eng_upd = 1;
    @(posedge clk); #1;
    eng_done = 0; eng_err = 0; eng_upd = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    n_err++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 run", {31'h0, chan_run}, 32'h0);
    chk("R1 pmap", {16'h0, periph_map}, {16'h0, PMAP_RST});
    rd(1, 6'h00, 32'h0, "R1 ndp");
    rd(1, 6'h28, 32'h0, "R1 status");
    // programming (R2, R3)
    bus(1, 1, 6'h00, 32'h1234_5678);
    bus(1, 1, 6'h04, 32'h8000_0100);
    bus(1, 0, 6'h04, 32'h5555_AAAA);
    rd(1, 6'h04, 32'h8000_AAAA, "R3 half write");
    rd(0, 6'h00, 32'h0000_5678, "R2 half read");
    bus(1, 1, 6'h10, 32'hBEEF_0000);
    rd(1, 6'h10, 32'h0, "R3 wide to narrow");
    bus(1, 1, 6'h14, 32'h4);
    bus(1, 1, 6'h18, 32'h3);
    bus(1, 1, 6'h1C, 32'h8);
    // peripheral map (R9)
    bus(1, 1, 6'h2C, 32'hFFFF);
    rd(1, 6'h2C, 32'hFFFF, "R9 pmap all ones");
    bus(1, 1, 6'h2C, 32'h0);
    rd(1, 6'h2C, 32'h0040, "R9 pmap keeps type");
    // undefined (R10)
    bus(1, 1, 6'h0C, 32'hDEAD_BEEF);
    chk("R10 pad write err", {31'h0, rsp_err}, 32'h1);
    rd(1, 6'h0C, 32'h0, "R10 pad read");
    bus(1, 1, 6'h02, 32'hFFFF_FFFF);
    chk("R10 misaligned err", {31'h0, rsp_err}, 32'h1);
    rd(1, 6'h00, 32'h1234_5678, "R10 no state change");
    bus(0, 1, 6'h05, 0);
    chk("R10 misaligned read", {31'h0, rsp_err}, 32'h1);
    // start (R5)
    bus(1, 0, 6'h08, 32'h0001);
    chk("R5 run", {31'h0, chan_run}, 32'h1);
    rd(1, 6'h30, 32'hFFFF, "R5 zero count loads ones");
    rd(1, 6'h38, 32'h3, "R5 y count");
    rd(1, 6'h24, 32'h8000_AAAA, "R5 curr addr");
    rd(1, 6'h20, 32'h1234_5678, "R5 curr desc");
    rd(1, 6'h28, 32'h8, "R5 status run");
    // locked writes (R4)
    bus(1, 1, 6'h10, 32'h5);
    chk("R4 no err", {31'h0, rsp_err}, 32'h0);
    rd(1, 6'h10, 32'h0, "R4 xcount dropped");
    bus(1, 1, 6'h04, 32'h1);
    rd(1, 6'h04, 32'h8000_AAAA, "R4 saddr dropped");
    bus(1, 1, 6'h2C, 32'h0003);
    rd(1, 6'h2C, 32'h0040, "R4 pmap dropped");
    bus(1, 1, 6'h30, 32'h9);
    rd(1, 6'h30, 32'hFFFF, "R4 curr x dropped");
    // engine update (R11)
    upd_addr = 32'h8000_0200; upd_x = 16'h7; upd_y = 16'h2;
    pulse(2);
    rd(1, 6'h24, 32'h8000_0200, "R11 upd addr");
    rd(1, 6'h30, 32'h7, "R11 upd x");
    rd(1, 6'h38, 32'h2, "R11 upd y");
    // status (R7, R8)
    pulse(1);
    rd(1, 6'h28, 32'hA, "R8 err set");
    bus(1, 0, 6'h28, 32'h000B);
    rd(1, 6'h28, 32'h8, "R7 w1c keeps run");
    pulse(0);
    chk("R8 done clears run", {31'h0, chan_run}, 32'h0);
    rd(1, 6'h28, 32'h1, "R8 done set");
    upd_addr = 32'h1111_1111;
    pulse(2);
    rd(1, 6'h24, 32'h8000_0200, "R11 idle upd ignored");
    // set wins over clear (R7)
    @(posedge clk); #1;
    req_valid = 1; req_write = 1; req_wide = 0; req_addr = 6'h28; req_wdata = 32'h3;
    eng_err = 1;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0; eng_err = 0;
    @(negedge clk);
    rd(1, 6'h28, 32'h2, "R7 set wins");
    // restart then stop (R6)
    bus(1, 0, 6'h08, 32'h0001);
    bus(1, 0, 6'h08, 32'h0000);
    chk("R6 run low", {31'h0, chan_run}, 32'h0);
    bus(1, 1, 6'h10, 32'h6);
    rd(1, 6'h10, 32'h6, "R4 unlocked after stop");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule